// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire management bus between a MAC and its PHYs. Software composes a complete 32-bit management frame word (start pattern, opcode, PHY address, register address, turnaround and data) and writes it to the frame register through a simple register port. The block then emits a preamble of 32 ones followed by the frame, most significant bit first, on the serial data line. It paces the bits with a management clock derived from the system clock. For a read opcode the block releases the data line for the second turnaround bit and the 16 data bits. It samples the returned bits on the rising management clock edge and merges them into the low half of the frame register.

Completion is reported through a sticky event bit that software clears by writing a one. A mask register decides whether the event reaches the interrupt pin, so a zero mask gives pure polling. A speed register sets the management clock half-period in system clocks. A self-clearing soft-reset bit returns the block to its idle state and aborts any frame in flight.

Register map (word addresses on `addr`, unlisted addresses read zero): 0 = control (bit 0 soft reset), 1 = event (bit 0 done), 2 = mask (bit 0), 3 = speed (half-period field in bits [6:1]), 4 = frame.

Top module: `mdio_frame_master`

## Requirements
- R1: A write to the frame register while idle, with a non-zero speed field and no soft reset active, starts a transaction that presents 32 ones and then the 32 frame bits, MSB first, one bit per management clock period, each bit stable across the rising edge.
- R2: The management clock half-period equals the speed field (speed register bits [6:1]) in system clocks; a frame has exactly 64 rising edges; the clock rests low whenever no frame is in flight.
- R3: For a frame whose bits [29:28] are 2'b10 (read), the output enable is low from stream bit 47 (second turnaround bit) to the end; for any other opcode it is high for the whole frame; it is low while idle.
- R4: For a read frame, the 16 bits sampled on rising clock edges at stream bits 48 to 63 land in frame register bits [15:0], first sampled bit in bit 15; bits [31:16] keep the written word.
- R5: The done event (event register bit 0) becomes readable exactly 128*H+1 system clocks after the frame-register write edge, H being the speed field.
- R6: Writing event bit 0 as 1 clears the done event (writing all ones clears it too); writing 0 leaves it set; a completion in the same cycle as a clear wins.
- R7: The interrupt output is high exactly while the done event and mask bit 0 are both set; with a zero mask it stays low.
- R8: With the speed field at zero, a frame-register write stores the word but produces no clock edge and no done event.
- R9: A frame-register write while a frame is in flight is ignored: the register readback and the frame on the wire are unchanged.
- R10: Writing 1 to control bit 0 aborts any frame and holds all registers at reset values for RST_CYCLES clocks, during which control bit 0 reads 1 and register writes are ignored; the bit then clears itself.
- R11: After reset every register reads zero and the clock, output enable and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for write and read |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr` (combinational) |
| irq | output | 1 | Masked done interrupt |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven towards the PHY |
| mdio_oe | output | 1 | Output enable for the serial data line |
| mdio_in | input | 1 | Serial data returned by the PHY |

## Verification
The hardest situations to reach from the ports are the ones that interrupt a frame: a second frame-register write landing mid-frame, and a soft reset arriving while the management clock is toggling. The bench gets there by starting a frame at a known edge and counting system clocks before issuing the disturbing write. It then checks the bit stream recorded by its PHY model, the readback and the absence of clock activity afterwards. A sweep over three speed settings, all 32 PHY addresses and both opcodes pins the exact completion latency, the clock half-period and the turnaround release point.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W = 32;
    localparam int PRE_LEN = 32;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int REG_W   = 32;
    localparam int OP_LSB  = 28;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_EVENT = 3'd1,
        RA_MASK  = 3'd2,
        RA_SPEED = 3'd3,
        RA_FRAME = 3'd4
    } reg_addr_e;

    // completion report from the shifter to the register file
    typedef struct packed {
        logic              valid;
        logic              is_rd;
        logic [DATA_W-1:0] data;
    } done_t;

    function automatic logic frame_is_read(input logic [FRAME_W-1:0] w);
        return w[OP_LSB+1:OP_LSB] == OP_RD;
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SPD_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [SPD_W-1:0] cnt;
    logic             wrap;

    assign wrap = en && (cnt == half - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_in,
    output logic               busy,
    output logic               is_rd,
    output logic               mdio_out,
    output logic               mdio_oe,
    output done_t              done
);
    localparam int STREAM = PRE_LEN + FRAME_W;
    localparam int IDX_W  = $clog2(STREAM);
    localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(STREAM - DATA_W);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(STREAM - DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STREAM - 1);

    logic [STREAM-1:0] sh;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata;

    assign mdio_out = busy & sh[STREAM-1];
    assign mdio_oe  = busy && !(is_rd && idx >= REL_IDX);

    always_ff @(posedge clk) begin
        done <= '0;
        if (rst) begin
            busy  <= 1'b0;
            sh    <= '0;
            idx   <= '0;
            is_rd <= 1'b0;
            rdata <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            sh    <= {{PRE_LEN{1'b1}}, frame_in};
            idx   <= '0;
            is_rd <= frame_is_read(frame_in);
            rdata <= '0;
        end else if (busy) begin
            if (rise && is_rd && idx >= CAP_IDX)
                rdata <= {rdata[DATA_W-2:0], mdio_in};
            if (fall) begin
                if (idx == LAST_IDX) begin
                    busy       <= 1'b0;
                    done.valid <= 1'b1;
                    done.is_rd <= is_rd;
                    done.data  <= rdata;
                end else begin
                    sh  <= sh << 1;
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPD_W      = 6,
    parameter int RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               busy,
    input  done_t              done,
    output logic               start,
    output logic [SPD_W-1:0]   spd,
    output logic [FRAME_W-1:0] frame_q,
    output logic               ev_done,
    output logic               irq,
    output logic               sr_active
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [RCW-1:0] sr_cnt;
    logic           mask_q;
    logic           clr;
    logic           wr_ctrl, wr_event, wr_mask, wr_speed, wr_frame;

    assign sr_active = (sr_cnt != '0);
    assign clr       = rst || sr_active;
    assign wr_ctrl   = wr_en && addr == RA_CTRL;
    assign wr_event  = wr_en && addr == RA_EVENT;
    assign wr_mask   = wr_en && addr == RA_MASK;
    assign wr_speed  = wr_en && addr == RA_SPEED;
    assign wr_frame  = wr_en && addr == RA_FRAME;
    assign start     = wr_frame && !busy && !sr_active && spd != '0;
    assign irq       = ev_done & mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_cnt <= '0;
        else if (sr_active)
            sr_cnt <= sr_cnt - 1'b1;
        else if (wr_ctrl && wr_data[0])
            sr_cnt <= RCW'(RST_CYCLES);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            mask_q  <= 1'b0;
            spd     <= '0;
            ev_done <= 1'b0;
            frame_q <= '0;
        end else begin
            if (wr_mask)
                mask_q <= wr_data[0];
            if (wr_speed)
                spd <= wr_data[SPD_W:1];
            if (wr_frame && !busy)
                frame_q <= wr_data;
            if (done.valid)
                ev_done <= 1'b1;
            else if (wr_event && wr_data[0])
                ev_done <= 1'b0;
            if (done.valid && done.is_rd)
                frame_q[DATA_W-1:0] <= done.data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_CTRL:  rd_data[0] = sr_active;
            RA_EVENT: rd_data[0] = ev_done;
            RA_MASK:  rd_data[0] = mask_q;
            RA_SPEED: rd_data[SPD_W:1] = spd;
            RA_FRAME: rd_data = frame_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int SPD_W      = 6,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic               busy;
    logic               is_rd;
    logic               start;
    logic               sr_active;
    logic               ev_done;
    logic               rise, fall;
    logic [SPD_W-1:0]   spd;
    logic [FRAME_W-1:0] frame_q;
    done_t              done;

    mdio_regs #(.SPD_W(SPD_W), .RST_CYCLES(RST_CYCLES)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .start(start), .spd(spd),
        .frame_q(frame_q), .ev_done(ev_done), .irq(irq), .sr_active(sr_active)
    );

    mdio_clkdiv #(.SPD_W(SPD_W)) div_i (
        .clk(clk), .rst(rst), .en(busy && !sr_active), .half(spd),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_shifter shift_i (
        .clk(clk), .rst(rst || sr_active), .start(start), .frame_in(wr_data),
        .rise(rise), .fall(fall), .mdio_in(mdio_in), .busy(busy), .is_rd(is_rd),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .done(done)
    );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk
    import mdio_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               is_rd,
    input logic               mdc,
    input logic               mdio_oe,
    input logic [SPD_W-1:0]   spd,
    input logic [FRAME_W-1:0] frame_q,
    input logic               ev_done,
    input logic               sr_active,
    input done_t              done
);
    p_mdc_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        mdc |-> busy);

    p_oe_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    p_oe_write_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_rd) |-> mdio_oe);

    p_rdata_merge_r4: assert property (@(posedge clk) disable iff (rst || sr_active)
        (done.valid && done.is_rd) |=> frame_q[DATA_W-1:0] == $past(done.data));

    p_done_event_r5: assert property (@(posedge clk) disable iff (rst || sr_active)
        done.valid |=> ev_done);

    p_no_start_r8: assert property (@(posedge clk) disable iff (rst)
        (spd == '0 && !busy) |=> !busy);

    p_frame_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(frame_q));

    p_sr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (sr_active && $past(sr_active)) |-> (!busy && !mdc));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.SPD_W(SPD_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .is_rd(is_rd), .mdc(mdc),
    .mdio_oe(mdio_oe), .spd(spd), .frame_q(frame_q), .ev_done(ev_done),
    .sr_active(sr_active), .done(done)
);

// File: tb/mdio_frame_master_tb_top.sv
module mdio_frame_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, mdc, mdio_out, mdio_oe, mdio_in;

    int n_chk = 0;
    int n_bad = 0;

    // PHY model / monitor state
    logic        prev_mdc = 1'b0;
    int          run_len = 0, tog = 0, rmin = 0, rmax = 0, nrise = 0;
    logic [63:0] mon_stream = '0, mon_oe = '0;
    logic [15:0] phy_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_master #(.SPD_W(6), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    assign mdio_in = (nrise >= 48 && nrise < 64) ? phy_data[63 - nrise] : 1'b1;

    always @(negedge clk) begin
        if (mdc != prev_mdc) begin
            if (run_len < rmin) rmin = run_len;
            if (run_len > rmax) rmax = run_len;
            tog = tog + 1;
            run_len = 1;
            if (mdc) begin
                mon_stream = {mon_stream[62:0], mdio_out};
                mon_oe     = {mon_oe[62:0], mdio_oe};
                nrise      = nrise + 1;
            end
        end else begin
            run_len = run_len + 1;
        end
        prev_mdc = mdc;
    end

    task automatic mon_clear();
        run_len = 1; tog = 0; rmin = 1000000; rmax = 0; nrise = 0;
        mon_stream = '0; mon_oe = '0;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic run_frame(input int h, input bit is_read, input int pa, input int rg,
                             input logic [15:0] val, input logic [15:0] pdat,
                             input bit msk, input int seq);
        logic [31:0] fr, v;
        logic [63:0] exp_s, dmask, exp_oe;
        int k;
        fr = is_read ? (32'h6002_0000 | (32'(pa) << 23) | (32'(rg) << 18))
                     : (32'h5002_0000 | (32'(pa) << 23) | (32'(rg) << 18) | 32'(val));
        phy_data = pdat;
        wr(3'd4, fr);
        mon_clear();
        k = 0;
        forever begin
            rd(3'd1, v);
            if (v[0] || k > 128*h + 40) break;
            @(negedge clk); #1;
            k++;
        end
        // R5: completion latency
        check(k == 128*h + 1, "R5 latency", 64'(k), 64'(128*h + 1));
        // R2: half-period and edge count
        check(tog == 128 && nrise == 64, "R2 edge count", 64'(tog), 64'd128);
        check(rmin == h && rmax == h, "R2 half period", 64'(rmax), 64'(h));
        // R1 / R3: stream and output enable
        exp_s  = {32'hFFFF_FFFF, fr};
        dmask  = is_read ? 64'hFFFF_FFFF_FFFE_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        exp_oe = dmask;
        check((mon_stream & dmask) == (exp_s & dmask), "R1 stream", mon_stream & dmask, exp_s & dmask);
        check(mon_oe == exp_oe, "R3 output enable", mon_oe, exp_oe);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
        // R4: readback
        rd(3'd4, v);
        if (is_read)
            check(v == {fr[31:16], pdat}, "R4 read data", 64'(v), 64'({fr[31:16], pdat}));
        else
            check(v == fr, "R4 write frame kept", 64'(v), 64'(fr));
        // R7: interrupt gating
        check(irq == msk, "R7 irq gating", 64'(irq), 64'(msk));
        // R6: clear-on-one
        if (seq % 4 == 0) begin
            wr(3'd1, 32'd0);
            rd(3'd1, v);
            check(v[0] == 1'b1, "R6 zero write keeps event", 64'(v), 64'd1);
        end
        if (seq % 2 == 0) wr(3'd1, 32'd1);
        else              wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v);
        check(v[0] == 1'b0 && irq == 1'b0, "R6 event cleared", 64'(v), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check(v == 32'd0, "R11 reset register", 64'(v), 64'd0);
        end
        check(mdc == 0 && mdio_oe == 0 && irq == 0, "R11 reset pins", {61'd0, mdc, mdio_oe, irq}, 64'd0);

        // sweep: speeds, PHY addresses, both opcodes
        seq = 0;
        for (int h = 1; h <= 3; h++) begin
            wr(3'd3, 32'(h) << 1);
            rd(3'd3, v);
            check(v == (32'(h) << 1), "R2 speed readback", 64'(v), 64'(32'(h) << 1));
            wr(3'd2, 32'(h % 2));
            for (int pa = 0; pa < 32; pa++) begin
                for (int op = 0; op < 2; op++) begin
                    logic [15:0] val;
                    val = 16'(pa * 16'h0913) ^ 16'(h * 16'h5a00) ^ 16'(op * 16'h00c3);
                    run_frame(h, op == 1, pa, (pa * 5 + h) % 32, val, ~val, bit'(h % 2), seq);
                    seq++;
                end
            end
        end

        // R9: frame write during a frame is ignored
        wr(3'd3, 32'd2 << 1);
        wr(3'd2, 32'd1);
        wr(3'd4, 32'h5002_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h1234);
        mon_clear();
        idle(40);
        wr(3'd4, 32'h6002_0000 | (32'd3 << 23));
        rd(3'd4, v);
        check(v == (32'h5002_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h1234), "R9 readback unchanged",
              64'(v), 64'(32'h5002_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h1234));
        idle(300);
        check(mon_stream == {32'hFFFF_FFFF, 32'h5002_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h1234},
              "R9 wire frame unchanged", mon_stream,
              {32'hFFFF_FFFF, 32'h5002_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h1234});
        check(tog == 128, "R9 single frame", 64'(tog), 64'd128);
        wr(3'd1, 32'd1);

        // R10: soft reset mid-frame
        wr(3'd4, 32'h6002_0000 | (32'd5 << 23) | (32'd1 << 18));
        idle(50);
        wr(3'd0, 32'd1);
        rd(3'd0, v);
        check(v[0] == 1'b1, "R10 reset bit set", 64'(v), 64'd1);
        wr(3'd2, 32'd1);
        @(negedge clk); #1;
        rd(3'd0, v);
        check(v[0] == 1'b1, "R10 reset bit held", 64'(v), 64'd1);
        @(negedge clk); #1;
        rd(3'd0, v);
        check(v[0] == 1'b0, "R10 reset bit self-clears", 64'(v), 64'd0);
        rd(3'd2, v);
        check(v == 32'd0, "R10 write ignored during reset", 64'(v), 64'd0);
        rd(3'd3, v);
        check(v == 32'd0, "R10 speed cleared", 64'(v), 64'd0);
        rd(3'd4, v);
        check(v == 32'd0, "R10 frame cleared", 64'(v), 64'd0);
        mon_clear();
        idle(300);
        rd(3'd1, v);
        check(v == 32'd0 && tog == 0 && mdio_oe == 0, "R10 frame aborted", 64'(v) | 64'(tog), 64'd0);

        // R8: zero speed issues no frame
        wr(3'd4, 32'h5002_0000 | 32'h00AA);
        mon_clear();
        idle(300);
        rd(3'd1, v);
        check(v == 32'd0 && tog == 0, "R8 no frame at zero speed", 64'(v) | 64'(tog), 64'd0);
        rd(3'd4, v);
        check(v == (32'h5002_0000 | 32'h00AA), "R8 word stored", 64'(v), 64'(32'h5002_00AA));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule